// File: doc/BRIEF.md
# Comma-Aligning Deserializer with Split Byte Clocks

This block runs on the recovered serial bit clock. Each cycle it takes one bit from `ser_in` and keeps the most recent 19 bits in a sliding window. Every ten bits it presents a 10-bit word on `word_out`, and it advances two byte clocks that are 180 degrees apart. Each byte clock has a period of twenty bit times. `bclk1` rises with the even words (0, 2, ...) and `bclk0` rises with the odd words. The oldest bit of each word is in bit 0.

When `align_en` is high, the block checks at every word end whether the K28.5 character completed at any of the ten most recent bit positions. If it did, the word boundary moves to that position. The data is taken from a different tap of the window, so the clocks are not slipped. A comma found on an even word end is output at once as the aligned word, and `sync_out` is raised for exactly one word time. A comma found on an odd word end cannot be output on `bclk1`. In that case the block holds both byte clocks for one extra word time, so the next comma twenty bits later falls on a `bclk1` rising edge. When `align_en` is low, the block does no search and the boundary stays where it is.

The control is a three-state machine:
- `ST_BYPASS`: alignment is off.
- `ST_HUNT`: the search is active.
- `ST_HOLD`: the byte clocks are being stretched.

Its transitions are:
- `ST_BYPASS`→`ST_HUNT` when `align_en` rises.
- `ST_HUNT`→`ST_BYPASS` when `align_en` falls.
- `ST_HUNT`→`ST_HOLD` on a comma found at an odd word end.
- `ST_HOLD`→`ST_HUNT` (or `ST_BYPASS` if `align_en` is low) after ten held bit times.

Top module: `comma_deser`

## Requirements
- R1: While `rst` is high, the outputs are `word_out`=0, `sync_out`=0, `bclk0`=1 and `bclk1`=0. After release, the first word appears after the tenth bit, together with a rise of `bclk1`.
- R2: `word_out` bit 0 is the earliest received bit of the word. `word_out` changes only when one of the byte clocks rises.
- R3: `bclk0` is always the complement of `bclk1`. Without realignment each clock toggles every 10 bit times, and `bclk1` rises on even-numbered words.
- R4: With `align_en` low, patterns in the stream (including K28.5 off the boundary) cause no boundary shift, and `sync_out` stays 0.
- R5: K28.5 is 0011111010 in receive order, which is `word_out` = 10'h17C. If it completes on the current boundary at an even word end, the boundary is unchanged, `word_out`=10'h17C and `sync_out` is high.
- R6: If K28.5 completes off the boundary and is found at an even word end, that word is output as 10'h17C with `sync_out`. All later words use the new boundary.
- R7: If K28.5 is found at an odd word end, the current high phase of `bclk0` is stretched by exactly 10 bit times. A K28.5 twenty bits later is then output on the `bclk1` rise with `sync_out`.
- R8: `sync_out` stays high for exactly 10 bit times. It rises only when `align_en` was high, and only together with a `bclk1` rise.
- R9: After the first toggle, no byte-clock phase is shorter than 10 or longer than 20 bit times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data, one bit per clock |
| align_en | input | 1 | Enables comma search and boundary moves |
| word_out | output | W | Deserialized word, bit 0 received first |
| bclk0 | output | 1 | Byte clock rising on odd words |
| bclk1 | output | 1 | Byte clock rising on even words, carries the comma |
| sync_out | output | 1 | One-word pulse marking an aligned comma |

## Verification
A wrong tap offset shows at the very next word end. From then on every word comes out rotated by a fixed number of bits, and the next comma is not flagged with `sync_out`. A wrong frame counter or stretch length shows one or two word times later, as a byte-clock phase that is not 10 bits long (or 20 bits when stretching), or as a comma arriving on the `bclk0` rise. A state machine stuck in search while `align_en` is low shows as a boundary that moves under a stray off-boundary comma, at the word end that follows it.

// File: rtl/cadsr_pkg.sv
package cadsr_pkg;

    // K28.5 with negative starting disparity, bit 0 received first
    parameter logic [9:0] K285_RX = 10'h17C;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_HUNT   = 2'd1,
        ST_HOLD   = 2'd2
    } align_state_e;

endpackage

// File: rtl/frame_timer.sv
// Twenty-bit frame position; frozen while the byte clocks are held.
module frame_timer #(
    parameter int W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic at_even,
    output logic at_odd
);
    localparam int SPAN = 2 * W;
    localparam int PW   = $clog2(SPAN);

    logic [PW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (!hold)
            pos_q <= (pos_q == PW'(SPAN - 1)) ? '0 : pos_q + 1'b1;
    end

    assign at_even = !hold && (pos_q == PW'(W - 1));
    assign at_odd  = !hold && (pos_q == PW'(SPAN - 1));
endmodule

// File: rtl/comma_scan.sv
// Compares every W-bit slice of the window against the pattern.
module comma_scan #(
    parameter int          W       = 10,
    parameter logic [W-1:0] PATTERN = 'h17C
) (
    input  logic [2*W-2:0]          win,
    output logic                    hit,
    output logic [$clog2(W)-1:0]    hit_off
);
    localparam int OW = $clog2(W);

    logic [W-1:0] match;

    genvar d;
    generate
        for (d = 0; d < W; d++) begin : g_off
            assign match[d] = (win[2*W-2-d -: W] == PATTERN);
        end
    endgenerate

    always_comb begin
        hit_off = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (match[i]) hit_off = OW'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/word_tap.sv
// Selects the W-bit slice that ends sel bits before the newest bit.
module word_tap #(
    parameter int W = 10
) (
    input  logic [2*W-2:0]       win,
    input  logic [$clog2(W)-1:0] sel,
    output logic [W-1:0]         word
);
    localparam int OW = $clog2(W);

    logic [W-1:0] cand [W];

    genvar d;
    generate
        for (d = 0; d < W; d++) begin : g_cand
            assign cand[d] = win[2*W-2-d -: W];
        end
    endgenerate

    always_comb begin
        word = cand[0];
        for (int i = 1; i < W; i++) begin
            if (sel == OW'(i)) word = cand[i];
        end
    end
endmodule

// File: rtl/comma_deser.sv
module comma_deser
    import cadsr_pkg::*;
#(
    parameter int           W       = 10,
    parameter logic [W-1:0] PATTERN = K285_RX
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_in,
    input  logic         align_en,
    output logic [W-1:0] word_out,
    output logic         bclk0,
    output logic         bclk1,
    output logic         sync_out
);
    localparam int WIN = 2 * W - 1;
    localparam int OW  = $clog2(W);

    align_state_e   st_q, st_d;
    logic [WIN-2:0] sh_q;
    logic [WIN-1:0] win;
    logic [OW-1:0]  off_q, hold_q, hit_off, tap_off;
    logic [W-1:0]   tap_word;
    logic           hit, at_even, at_odd, search, in_hold;

    assign win     = {ser_in, sh_q};
    assign in_hold = (st_q == ST_HOLD);
    assign search  = (st_q == ST_HUNT) && align_en;
    assign tap_off = (search && hit && at_even) ? hit_off : off_q;

    frame_timer #(.W(W)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .hold    (in_hold),
        .at_even (at_even),
        .at_odd  (at_odd)
    );

    comma_scan #(.W(W), .PATTERN(PATTERN)) u_scan (
        .win     (win),
        .hit     (hit),
        .hit_off (hit_off)
    );

    word_tap #(.W(W)) u_tap (
        .win  (win),
        .sel  (tap_off),
        .word (tap_word)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BYPASS: if (align_en) st_d = ST_HUNT;
            ST_HUNT: begin
                if (!align_en)           st_d = ST_BYPASS;
                else if (hit && at_odd)  st_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (hold_q == OW'(W - 1))
                    st_d = align_en ? ST_HUNT : ST_BYPASS;
            end
            default: st_d = ST_BYPASS;
        endcase
    end

    // state register, window, boundary offset, stretch count
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_BYPASS;
            sh_q   <= '0;
            off_q  <= '0;
            hold_q <= '0;
        end else begin
            st_q   <= st_d;
            sh_q   <= win[WIN-1:1];
            hold_q <= in_hold ? hold_q + 1'b1 : '0;
            if (search && hit && (at_even || at_odd))
                off_q <= hit_off;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            word_out <= '0;
            sync_out <= 1'b0;
            bclk0    <= 1'b1;
            bclk1    <= 1'b0;
        end else if (at_even) begin
            word_out <= tap_word;
            sync_out <= search && hit;
            bclk1    <= 1'b1;
            bclk0    <= 1'b0;
        end else if (at_odd) begin
            word_out <= tap_word;
            sync_out <= 1'b0;
            bclk1    <= 1'b0;
            bclk0    <= 1'b1;
        end
    end
endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk #(
    parameter int           W       = 10,
    parameter logic [W-1:0] PATTERN = 'h17C
) (
    input logic         clk,
    input logic         rst,
    input logic         align_en,
    input logic [W-1:0] word_out,
    input logic         bclk0,
    input logic         bclk1,
    input logic         sync_out
);
    localparam int CW = $clog2(2 * W + 2) + 1;

    logic          b1_q;
    logic [CW-1:0] age_q;

    // length of the current bclk1 phase
    always_ff @(posedge clk) begin
        if (rst) begin
            b1_q  <= 1'b0;
            age_q <= '0;
        end else begin
            b1_q  <= bclk1;
            if (bclk1 != b1_q)  age_q <= CW'(1);
            else if (age_q != '1) age_q <= age_q + 1'b1;
        end
    end

    assert_clk_compl_R3: assert property (@(posedge clk) disable iff (rst)
        bclk0 != bclk1);

    assert_word_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (!$rose(bclk0) && !$rose(bclk1)) |-> $stable(word_out));

    assert_sync_comma_R5: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> (word_out == PATTERN && bclk1));

    assert_sync_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_out) |-> ($past(align_en) && $rose(bclk1)));

    assert_phase_len_R9: assert property (@(posedge clk) disable iff (rst)
        (bclk1 != b1_q) |-> (age_q >= CW'(W) && age_q <= CW'(2 * W)));

    assert_stretch_cap_R7: assert property (@(posedge clk) disable iff (rst)
        age_q <= CW'(2 * W));
endmodule

bind comma_deser comma_deser_chk #(.W(W), .PATTERN(PATTERN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .align_en (align_en),
    .word_out (word_out),
    .bclk0    (bclk0),
    .bclk1    (bclk1),
    .sync_out (sync_out)
);

// File: tb/comma_deser_test.sv
module comma_deser_test;
    localparam int W  = 10;
    localparam int NB = 400;
    localparam logic [9:0] KCH = 10'h17C;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       align_en = 1'b0;
    logic [9:0] word_out;
    logic       bclk0, bclk1, sync_out;

    always #5 clk = ~clk;

    comma_deser uut (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .align_en (align_en),
        .word_out (word_out),
        .bclk0    (bclk0),
        .bclk1    (bclk1),
        .sync_out (sync_out)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic       tb_bits [NB];
    logic [9:0] lw  [NB];
    logic       lb0 [NB];
    logic       lb1 [NB];
    logic       ls  [NB];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // word ending d bits before edge e, bit 0 oldest
    function automatic logic [9:0] exp_word(input int e, input int d);
        logic [9:0] w;
        for (int i = 0; i < 10; i++) w[i] = tb_bits[e - d - 9 + i];
        return w;
    endfunction

    // random bits without five ones in a row, so no comma can form
    task automatic make_filler();
        int ones = 0;
        for (int i = 0; i < NB; i++) begin
            logic b = 1'($urandom % 2);
            if (ones == 4) b = 1'b0;
            ones = b ? ones + 1 : 0;
            tb_bits[i] = b;
        end
    endtask

    task automatic put_comma(input int c_end);
        for (int i = 0; i < 10; i++) tb_bits[c_end - 9 + i] = KCH[i];
    endtask

    task automatic run(input bit en);
        align_en = en;
        rst      = 1'b1;
        ser_in   = 1'b0;
        repeat (3) @(negedge clk);
        check(word_out == 10'd0, "R1 reset word", int'(word_out), 0);
        check(sync_out == 1'b0 && bclk0 == 1'b1 && bclk1 == 1'b0, "R1 reset clocks",
              int'({bclk1, bclk0, sync_out}), 2);
        rst = 1'b0;
        for (int n = 0; n < NB; n++) begin
            ser_in = tb_bits[n];
            @(posedge clk);
            @(negedge clk);
            lw[n]  = word_out;
            lb0[n] = bclk0;
            lb1[n] = bclk1;
            ls[n]  = sync_out;
        end
    endtask

    // complementary clocks and phase lengths over the whole log
    task automatic check_phases();
        int  len   = 1;
        bit  first = 1;
        bit  compl_ok = 1;
        for (int n = 0; n < NB; n++) if (lb0[n] == lb1[n]) compl_ok = 0;
        check(compl_ok, "R3 complementary", 0, 1);
        for (int n = 1; n < NB; n++) begin
            if (lb1[n] != lb1[n-1]) begin
                if (!first) check(len >= 10 && len <= 20, "R9 phase length", len, 10);
                first = 0;
                len   = 1;
            end else begin
                len++;
            end
        end
    endtask

    // nominal byte-clock schedule with no stretch
    task automatic check_nominal_clocks(input int upto);
        for (int n = 0; n < upto; n++) begin
            logic eb1 = (n < 9) ? 1'b0 : ((((n - 9) / 10) % 2) == 0);
            if (lb1[n] != eb1) check(0, "R3 bclk1 schedule", int'(lb1[n]), int'(eb1));
        end
        check(1, "R3 bclk1 schedule", 0, 0);
    endtask

    task automatic check_words(input int e_from, input int e_to, input int d, input string req);
        for (int e = e_from; e <= e_to; e += 10)
            check(lw[e] == exp_word(e, d), req, int'(lw[e]), int'(exp_word(e, d)));
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // S1: alignment off, commas off the boundary are ignored
        make_filler();
        put_comma(24);
        put_comma(53);
        run(1'b0);
        check(lb1[8] == 1'b0 && lb1[9] == 1'b1, "R1 first word on bclk1", int'(lb1[9]), 1);
        check(lw[9] == exp_word(9, 0), "R1 first word", int'(lw[9]), int'(exp_word(9, 0)));
        check_words(9, 389, 0, "R2/R4 unframed words");
        begin
            int cnt = 0;
            for (int n = 0; n < NB; n++) if (ls[n]) cnt++;
            check(cnt == 0, "R4 no sync when disabled", cnt, 0);
        end
        check_nominal_clocks(NB);
        check_phases();

        // S2: comma already on an even boundary
        make_filler();
        put_comma(29);
        put_comma(69);
        run(1'b1);
        check(lw[29] == KCH && ls[29] == 1'b1, "R5 aligned comma", int'(lw[29]), int'(KCH));
        begin
            bit hi = 1;
            for (int n = 29; n <= 38; n++) if (!ls[n]) hi = 0;
            check(hi && !ls[28] && !ls[39], "R8 sync one word", int'({ls[28], ls[39]}), 0);
        end
        check(lw[69] == KCH && ls[69] == 1'b1, "R5 second comma", int'(lw[69]), int'(KCH));
        check_words(9, 389, 0, "R5 boundary unchanged");
        check_nominal_clocks(NB);
        check_phases();

        // S3: comma off the boundary, found on an even word end
        make_filler();
        put_comma(42);
        put_comma(82);
        run(1'b1);
        check_words(9, 39, 0, "R6 before shift");
        check(lw[49] == KCH && ls[49] == 1'b1, "R6 shifted comma", int'(lw[49]), int'(KCH));
        check_words(59, 79, 7, "R6 new boundary");
        check(lw[89] == KCH && ls[89] == 1'b1, "R6 next comma", int'(lw[89]), int'(KCH));
        check_words(99, 389, 7, "R6 new boundary kept");
        check_nominal_clocks(NB);
        check_phases();

        // S4: comma found on an odd word end, clocks stretched
        make_filler();
        put_comma(34);
        put_comma(54);
        put_comma(94);
        run(1'b1);
        check(lw[39] == exp_word(39, 0) && ls[39] == 1'b0, "R7 odd word unsynced",
              int'(lw[39]), int'(exp_word(39, 0)));
        begin
            bit held = 1;
            for (int n = 39; n <= 58; n++) if (!lb0[n] || lb1[n]) held = 0;
            check(held, "R7 bclk0 held 20 bits", 0, 1);
        end
        check(lb1[59] == 1'b1 && lb0[59] == 1'b0, "R7 bclk1 after stretch", int'(lb1[59]), 1);
        check(lw[59] == KCH && ls[59] == 1'b1, "R7 comma on bclk1", int'(lw[59]), int'(KCH));
        check_words(69, 89, 5, "R7 words after stretch");
        check(lw[99] == KCH && ls[99] == 1'b1, "R7 later comma", int'(lw[99]), int'(KCH));
        check_phases();

        // S5: random comma positions
        for (int t = 0; t < 6; t++) begin
            int c  = 20 + int'($urandom % 131);
            int k  = (c - 9 + 9) / 10;
            int e1 = 10 * k + 9;
            int d  = e1 - c;
            make_filler();
            put_comma(c);
            put_comma(c + 20);
            run(1'b1);
            if ((k % 2) == 0) begin
                check(lw[e1] == KCH && ls[e1] == 1'b1, "R6 random even comma", int'(lw[e1]), int'(KCH));
                check(lw[e1+10] == exp_word(e1 + 10, d), "R6 random next word",
                      int'(lw[e1+10]), int'(exp_word(e1 + 10, d)));
                check(lw[e1+20] == KCH && ls[e1+20] == 1'b1, "R5 random repeat",
                      int'(lw[e1+20]), int'(KCH));
            end else begin
                check(ls[e1] == 1'b0 && lb0[e1+19] == 1'b1 && lb1[e1+20] == 1'b1,
                      "R7 random stretch", int'({ls[e1], lb0[e1+19], lb1[e1+20]}), 3);
                check(lw[e1+20] == KCH && ls[e1+20] == 1'b1, "R7 random comma",
                      int'(lw[e1+20]), int'(KCH));
                check(lw[e1+30] == exp_word(e1 + 30, d), "R7 random next word",
                      int'(lw[e1+30]), int'(exp_word(e1 + 30, d)));
            end
            check_phases();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule